// File: doc/BRIEF.md
# Thermal Warning and Shutdown Supervisor

This block turns three digital temperature comparator levels into a readable warning flag, a latched shutdown flag and a gate-enable mask for the four half bridges of a power stage. The three levels are: over the warning level, over the shutdown level, and under the release level. Each level passes through a two-flop synchroniser and a run-length glitch filter before the flag logic uses it.

Once the shutdown flag is set, every high-side and low-side gate enable is pulled low and the global disable is raised. Cooling by itself does not clear the flag. The host must pulse a clear strobe, and the clear takes effect only if the filtered under-release level is asserted in that same cycle. The host clears the warning flag with a read-clear strobe. That strobe has no effect while the filtered warning level is still asserted.

Top module: `thermal_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, both flags read 0, `out_disable_o` is 0 and every bit of `hs_allow_o` and `ls_allow_o` is 1.
- R2: A raw comparator level is seen by the flag logic only after it has held a new value for 4 consecutive clocks, measured after 2 synchroniser flops. A level that holds at least 4 cycles first changes a flag at the 7th rising edge after the raw change. A pulse of 3 cycles or fewer has no effect.
- R3: A filtered warning level of 1 sets `warn_flag_o` on the next edge, and the flag stays at 1 while that level is 1.
- R4: `warn_rdclr_i` clears `warn_flag_o` on the next edge only when the filtered warning level is 0. In any other cycle the strobe is ignored and the flag stays at 1.
- R5: A filtered shutdown level of 1 sets `shut_flag_o` on the next edge. The flag stays at 1 after the level drops until R8 clears it.
- R6: While `shut_flag_o` is 1, `out_disable_o` is 1 and all bits of `hs_allow_o` and `ls_allow_o` are 0. Bit i of each vector belongs to half bridge i.
- R7: A `shut_clr_i` pulse in a cycle where the filtered under-release level is 0 is ignored, and `shut_flag_o` stays at 1.
- R8: A `shut_clr_i` pulse in a cycle where the filtered under-release level is 1 clears `shut_flag_o` on the next edge, and all outputs are enabled again. Cooling with no clear pulse leaves the flag at 1.
- R9: If the filtered shutdown level and a valid clear meet in the same cycle, the set wins and `shut_flag_o` stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| warn_cmp_i | input | 1 | Raw level: temperature over the warning threshold |
| shut_cmp_i | input | 1 | Raw level: temperature over the shutdown threshold |
| cool_cmp_i | input | 1 | Raw level: temperature under the release (hysteresis) level |
| shut_clr_i | input | 1 | Host strobe that clears the shutdown flag |
| warn_rdclr_i | input | 1 | Host read-clear strobe for the warning flag |
| warn_flag_o | output | 1 | Warning flag |
| shut_flag_o | output | 1 | Latched shutdown flag |
| out_disable_o | output | 1 | Global power stage disable |
| hs_allow_o | output | 4 | High-side gate enables, one per half bridge |
| ls_allow_o | output | 4 | Low-side gate enables, one per half bridge |

## Verification
The comparator levels are driven with short glitches of 3 cycles and with long steady levels. This shows whether the filter rejects noise or accepts a real crossing at exactly the expected edge. Clear strobes are sent while the filtered level is hot, while it is warm but not cooled, after cooling, and in the same cycle as an active shutdown level. Together these separate a sticky flag from a self-clearing one and show that set wins over clear. A per-cycle reference model checks every flag and enable on every clock, so an error of one cycle in the filter or the flag registers shows up as a mismatch.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
    localparam int NUM_CMP  = 3;
    localparam int IDX_WARN = 0;
    localparam int IDX_SHUT = 1;
    localparam int IDX_COOL = 2;

    typedef struct packed {
        logic warn;
        logic shut;
    } flag_s;
endpackage

// File: rtl/cmp_conditioner.sv
module cmp_conditioner #(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic sync_o,
    output logic level_o
);
    localparam int CW = $clog2(FILT_LEN + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic [CW-1:0] run;
        logic          level;
    } cond_s;

    cond_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[0], raw_i};
        if (st_q.sync[1] != st_q.level) begin
            if (st_q.run == CW'(FILT_LEN - 1)) begin
                st_d.level = st_q.sync[1];
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + 1'b1;
            end
        end else begin
            st_d.run = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o  = st_q.sync[1];
    assign level_o = st_q.level;
endmodule

// File: rtl/thermal_flags.sv
module thermal_flags
    import thermal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hot_warn_i,
    input  logic hot_shut_i,
    input  logic cooled_i,
    input  logic shut_clr_i,
    input  logic warn_rdclr_i,
    output logic warn_o,
    output logic shut_o
);
    flag_s fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        // set dominates clear (R9); clear needs cooled level (R7, R8)
        if (hot_shut_i)                   fl_d.shut = 1'b1;
        else if (shut_clr_i && cooled_i)  fl_d.shut = 1'b0;
        // read-clear only once the warning level has dropped (R4)
        if (hot_warn_i)                   fl_d.warn = 1'b1;
        else if (warn_rdclr_i)            fl_d.warn = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign warn_o = fl_q.warn;
    assign shut_o = fl_q.shut;
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_pkg::*;
#(
    parameter int NUM_BRIDGES = 4,
    parameter int FILT_LEN    = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   warn_cmp_i,
    input  logic                   shut_cmp_i,
    input  logic                   cool_cmp_i,
    input  logic                   shut_clr_i,
    input  logic                   warn_rdclr_i,
    output logic                   warn_flag_o,
    output logic                   shut_flag_o,
    output logic                   out_disable_o,
    output logic [NUM_BRIDGES-1:0] hs_allow_o,
    output logic [NUM_BRIDGES-1:0] ls_allow_o
);
    logic [NUM_CMP-1:0] raw_w;
    logic [NUM_CMP-1:0] sync_w;
    logic [NUM_CMP-1:0] filt_w;
    logic               shut_w;

    assign raw_w[IDX_WARN] = warn_cmp_i;
    assign raw_w[IDX_SHUT] = shut_cmp_i;
    assign raw_w[IDX_COOL] = cool_cmp_i;

    for (genvar g = 0; g < NUM_CMP; g++) begin : g_cond
        cmp_conditioner #(.FILT_LEN(FILT_LEN)) u_cond (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (raw_w[g]),
            .sync_o  (sync_w[g]),
            .level_o (filt_w[g])
        );
    end

    thermal_flags u_flags (
        .clk          (clk),
        .rst_n        (rst_n),
        .hot_warn_i   (filt_w[IDX_WARN]),
        .hot_shut_i   (filt_w[IDX_SHUT]),
        .cooled_i     (filt_w[IDX_COOL]),
        .shut_clr_i   (shut_clr_i),
        .warn_rdclr_i (warn_rdclr_i),
        .warn_o       (warn_flag_o),
        .shut_o       (shut_w)
    );

    for (genvar b = 0; b < NUM_BRIDGES; b++) begin : g_gate
        assign hs_allow_o[b] = ~shut_w;
        assign ls_allow_o[b] = ~shut_w;
    end

    assign shut_flag_o   = shut_w;
    assign out_disable_o = shut_w;
endmodule

// File: rtl/thermal_guard_chk.sv
module thermal_guard_chk #(
    parameter int NB = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    sync_w,
    input logic [2:0]    filt_w,
    input logic          shut_clr_i,
    input logic          warn_rdclr_i,
    input logic          warn_flag_o,
    input logic          shut_flag_o,
    input logic          out_disable_o,
    input logic [NB-1:0] hs_allow_o,
    input logic [NB-1:0] ls_allow_o
);
    assert_filter_follows_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt_w ^ $past(filt_w)) & (filt_w ^ $past(sync_w))) == 3'b000);

    assert_warn_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        filt_w[0] |=> warn_flag_o);

    assert_warn_clear_cool_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(warn_flag_o) |-> $past(warn_rdclr_i && !filt_w[0]));

    assert_shut_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        filt_w[1] |=> shut_flag_o);

    assert_shut_rise_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(shut_flag_o) |-> $past(filt_w[1]));

    assert_gates_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        shut_flag_o |-> (out_disable_o && hs_allow_o == '0 && ls_allow_o == '0));

    assert_gates_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !shut_flag_o |-> (!out_disable_o && (&hs_allow_o) && (&ls_allow_o)));

    assert_clear_needs_cool_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(shut_flag_o) |-> $past(shut_clr_i && filt_w[2]));

    assert_set_beats_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_w[1] && shut_clr_i) |=> shut_flag_o);
endmodule

bind thermal_guard thermal_guard_chk #(.NB(NUM_BRIDGES)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .sync_w        (sync_w),
    .filt_w        (filt_w),
    .shut_clr_i    (shut_clr_i),
    .warn_rdclr_i  (warn_rdclr_i),
    .warn_flag_o   (warn_flag_o),
    .shut_flag_o   (shut_flag_o),
    .out_disable_o (out_disable_o),
    .hs_allow_o    (hs_allow_o),
    .ls_allow_o    (ls_allow_o)
);

// File: tb/sim_thermal_guard.sv
`timescale 1ns/1ps
module sim_thermal_guard;
    localparam int NB = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic warn_cmp = 1'b0, shut_cmp = 1'b0, cool_cmp = 1'b0;
    logic shut_clr = 1'b0, warn_rdclr = 1'b0;
    logic warn_flag, shut_flag, out_dis;
    logic [NB-1:0] hs_allow, ls_allow;

    always #2.5 clk = ~clk;

    thermal_guard #(.NUM_BRIDGES(NB), .FILT_LEN(4)) u0 (
        .clk(clk), .rst_n(rst_n),
        .warn_cmp_i(warn_cmp), .shut_cmp_i(shut_cmp), .cool_cmp_i(cool_cmp),
        .shut_clr_i(shut_clr), .warn_rdclr_i(warn_rdclr),
        .warn_flag_o(warn_flag), .shut_flag_o(shut_flag), .out_disable_o(out_dis),
        .hs_allow_o(hs_allow), .ls_allow_o(ls_allow)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    string cur_req = "R1";

    // behavioural reference: history queue of raw samples, run lengths, flags
    logic [2:0] hq[$];
    int         run_len[3];
    bit         m_lvl[3];
    bit         m_warn, m_shut;

    always @(posedge clk) begin
        if (!rst_n) begin
            hq.delete();
            for (int k = 0; k < 3; k++) begin run_len[k] = 0; m_lvl[k] = 0; end
            m_warn = 0; m_shut = 0;
        end else begin
            logic [2:0] seen;
            if (m_lvl[1]) m_shut = 1;
            else if (shut_clr && m_lvl[2]) m_shut = 0;
            if (m_lvl[0]) m_warn = 1;
            else if (warn_rdclr) m_warn = 0;
            hq.push_back({cool_cmp, shut_cmp, warn_cmp});
            if (hq.size() > 3) void'(hq.pop_front());
            seen = (hq.size() == 3) ? hq[0] : 3'b000;
            for (int k = 0; k < 3; k++) begin
                if (seen[k] != m_lvl[k]) begin
                    run_len[k]++;
                    if (run_len[k] == 4) begin m_lvl[k] = seen[k]; run_len[k] = 0; end
                end else run_len[k] = 0;
            end
        end
    end

    task automatic check(string what, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", cur_req, what, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        check("warn_flag", 32'(warn_flag), 32'(m_warn));
        check("shut_flag", 32'(shut_flag), 32'(m_shut));
        check("out_disable R6", 32'(out_dis), 32'(m_shut));
        check("hs_allow R6", 32'(hs_allow), m_shut ? 32'h0 : 32'((1 << NB) - 1));
        check("ls_allow R6", 32'(ls_allow), m_shut ? 32'h0 : 32'((1 << NB) - 1));
    end

    task automatic step(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic pulse_clr();
        shut_clr = 1; step(1); shut_clr = 0;
    endtask

    task automatic pulse_rdclr();
        warn_rdclr = 1; step(1); warn_rdclr = 0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        cur_req = "R1 reset";
        step(3);
        rst_n = 1;
        step(2);
        check("R1 flags after reset", 32'({warn_flag, shut_flag}), 32'h0);

        cur_req = "R2 glitch rejected";
        warn_cmp = 1; shut_cmp = 1; step(3); warn_cmp = 0; shut_cmp = 0;
        step(10);
        check("R2 no flag from 3-cycle pulse", 32'({warn_flag, shut_flag}), 32'h0);

        cur_req = "R2 R3 warning set latency";
        warn_cmp = 1; step(6);
        check("R2 warn not yet at edge 6", 32'(warn_flag), 32'h0);
        step(1);
        check("R2 R3 warn set at edge 7", 32'(warn_flag), 32'h1);
        step(4);

        cur_req = "R4 read-clear while hot ignored";
        pulse_rdclr(); step(2);
        check("R4 warn held", 32'(warn_flag), 32'h1);
        warn_cmp = 0; step(8);
        cur_req = "R4 read-clear when cool";
        pulse_rdclr(); step(1);
        check("R4 warn cleared", 32'(warn_flag), 32'h0);

        cur_req = "R5 R6 shutdown sets";
        shut_cmp = 1; warn_cmp = 1; step(10);
        check("R5 shut set", 32'(shut_flag), 32'h1);
        check("R6 gates off", 32'({hs_allow, ls_allow}), 32'h0);
        shut_cmp = 0; step(12);
        check("R5 shut sticky after level drop", 32'(shut_flag), 32'h1);

        cur_req = "R7 clear without release ignored";
        pulse_clr(); step(2);
        check("R7 shut held", 32'(shut_flag), 32'h1);

        cur_req = "R8 cooling alone keeps shutdown";
        cool_cmp = 1; step(12);
        check("R8 shut held without clear", 32'(shut_flag), 32'h1);
        cur_req = "R8 clear after release";
        pulse_clr(); step(1);
        check("R8 shut cleared", 32'(shut_flag), 32'h0);
        check("R8 gates back on", 32'(out_dis), 32'h0);

        cur_req = "R9 set beats clear";
        shut_cmp = 1; step(8);
        shut_clr = 1; step(4); shut_clr = 0; step(1);
        check("R9 shut held during clear", 32'(shut_flag), 32'h1);
        shut_cmp = 0; step(8);
        cur_req = "R8 final clear";
        pulse_clr(); step(2);
        check("R8 shut cleared at end", 32'(shut_flag), 32'h0);

        warn_cmp = 0; cool_cmp = 0; step(10);
        finish_run();
    end

    initial begin
        wait (cycles > 5000);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
        finish_run();
    end
endmodule